// File: doc/BRIEF.md
# Coalescing Miss Buffer with Speculative Forwarding

This block holds a few in-flight line requests between a load/store unit and the next memory level. Loads to a line that is already in flight join the existing entry instead of opening a new one, so each line is read once. When the line comes back, one broadcast hands the data to every waiting load tag. Stores to an in-flight line are merged byte by byte into the entry, and the entry later sends a single write that carries only the newest bytes.

Each request may be flagged as non-cacheable. The flag travels with the outbound read, and the broadcast tells the requester not to install the line in any cache. An early lookup compares only address bits [11:6] of an incoming load against the live entries and raises a speculative forward of that entry's data in the same cycle. One cycle later a compare on the full line address either confirms or squashes that forward. A squash changes no entry state; the requester uses it to flush and replay.

Top module: `coalescing_fill_buf`

## Requirements
- R1: Loads whose address bits [31:6] match a live entry join that entry, and only one read request goes out per entry. Each outbound request carries the entry index on `mem_req_id`, and a new line takes the lowest-numbered free entry.
- R2: In the cycle `fill_valid` is high, `rsp_valid` is high, and bit t of `rsp_tags` is set for every load tag t that joined the entry named by `fill_ent`. `rsp_data` carries the line.
- R3: Stores to a live line merge into it. The entry sends one write whose `mem_req_be` is the OR of all merged byte enables and whose data holds the newest value of each byte. An entry with waiting loads writes after its fill; a store-only entry writes at once.
- R4: Returning fill bytes never replace bytes that a merged store has written, both in the broadcast and in the write data.
- R5: A request with `req_nocache` high marks its entry. That entry's read has `mem_req_nocache` high, and its broadcast has `rsp_alloc` low. Otherwise `rsp_alloc` is high.
- R6: An accepted load whose bits [11:6] equal those of a live entry raises `spec_fwd_valid` in the same cycle. `spec_fwd_ent` names the lowest such entry, and `spec_fwd_data` holds that entry's current data. Stores never raise it.
- R7: In the cycle after a speculative forward, exactly one of `fwd_confirm` and `fwd_squash` is high. `fwd_confirm` is high when bits [31:6] of the load equal the named entry's line address. Both are low in any other cycle.
- R8: When every entry is live and the request's line matches none of them, `req_ready` is low. A request to a live line is still accepted.
- R9: An entry stays live through the cycle after its fill broadcast and after its write is accepted, and it can take a new line in the cycle that follows.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid`, `mem_req_addr`, `mem_req_write` and `mem_req_id` hold their values.
- R11: After reset `req_ready` is high, and `mem_req_valid`, `rsp_valid`, `spec_fwd_valid`, `fwd_confirm` and `fwd_squash` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request from the load/store unit |
| req_ready | output | 1 | Request accepted this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_nocache | input | 1 | Non-cacheable / non-temporal access |
| req_addr | input | 32 | Byte address; bits [5:0] are ignored |
| req_tag | input | 3 | Load tag |
| req_wdata | input | 512 | Store data for the line |
| req_be | input | 64 | Store byte enables |
| spec_fwd_valid | output | 1 | Early forward on a low-bit match |
| spec_fwd_ent | output | 2 | Entry that was forwarded |
| spec_fwd_data | output | 512 | Forwarded entry data |
| fwd_confirm | output | 1 | Full compare agrees with the last forward |
| fwd_squash | output | 1 | Full compare rejects the last forward |
| mem_req_valid | output | 1 | Outbound request |
| mem_req_ready | input | 1 | Memory port accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_nocache | output | 1 | Do not allocate in any cache |
| mem_req_id | output | 2 | Entry index |
| mem_req_addr | output | 32 | Line-aligned address |
| mem_req_be | output | 64 | Write byte enables |
| mem_req_wdata | output | 512 | Write data |
| fill_valid | input | 1 | Fill data returning |
| fill_ent | input | 2 | Entry the fill belongs to |
| fill_data | input | 512 | Fill line |
| rsp_valid | output | 1 | Broadcast to waiting loads |
| rsp_tags | output | 8 | Waiting load tags, one bit per tag |
| rsp_data | output | 512 | Line data after the store merge |
| rsp_alloc | output | 1 | Line may be installed in a cache |

## Verification
A lost waiter bit or a stale line address stays hidden until the fill for that entry returns. At that point it appears as a missing bit in `rsp_tags`, or as a second read for the same line one cycle after the first is accepted. Wrong byte-valid state shows up on `rsp_data` and later on `mem_req_wdata`, in the broadcast cycle and the cycle after it. Errors in the partial or full compare show up at once: on `spec_fwd_valid` in the cycle the load is accepted, and on `fwd_confirm`/`fwd_squash` one cycle later.

// File: rtl/coalescing_fill_buf.sv
module coalescing_fill_buf #(
  parameter int NE  = 4,
  parameter int AW  = 32,
  parameter int LB  = 64,
  parameter int NT  = 8,
  parameter int PLO = 6,
  parameter int PHI = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_store,
  input  logic                   req_nocache,
  input  logic [AW-1:0]          req_addr,
  input  logic [$clog2(NT)-1:0]  req_tag,
  input  logic [8*LB-1:0]        req_wdata,
  input  logic [LB-1:0]          req_be,
  output logic                   spec_fwd_valid,
  output logic [$clog2(NE)-1:0]  spec_fwd_ent,
  output logic [8*LB-1:0]        spec_fwd_data,
  output logic                   fwd_confirm,
  output logic                   fwd_squash,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic                   mem_req_write,
  output logic                   mem_req_nocache,
  output logic [$clog2(NE)-1:0]  mem_req_id,
  output logic [AW-1:0]          mem_req_addr,
  output logic [LB-1:0]          mem_req_be,
  output logic [8*LB-1:0]        mem_req_wdata,
  input  logic                   fill_valid,
  input  logic [$clog2(NE)-1:0]  fill_ent,
  input  logic [8*LB-1:0]        fill_data,
  output logic                   rsp_valid,
  output logic [NT-1:0]          rsp_tags,
  output logic [8*LB-1:0]        rsp_data,
  output logic                   rsp_alloc
);
  localparam int OFF = $clog2(LB);
  localparam int LAW = AW - OFF;
  localparam int DW  = 8 * LB;
  localparam int IW  = $clog2(NE);

  logic [NE-1:0]  v, rdn, rds, fil, wrn, wrs, nc;
  logic [LAW-1:0] la  [NE];
  logic [DW-1:0]  dat [NE];
  logic [LB-1:0]  bv  [NE];
  logic [NT-1:0]  wt  [NE];

  logic [LAW-1:0] rl;
  logic [NE-1:0]  hit, part, rdc, wrc, done, clo;
  logic [IW-1:0]  fidx, pidx, sel, sel_q, se_q, rsel, wsel;
  logic           rany, wany, mv, sw, lock_q, sw_q, sv_q, accept, acc, full_eq;
  logic [LAW-1:0] sl_q;
  logic [DW-1:0]  fm;

  assign rl = req_addr[AW-1:OFF];

  always_comb begin
    rany = 1'b0; wany = 1'b0; rsel = '0; wsel = '0;
    for (int i = NE-1; i >= 0; i--) begin
      if (v[i] && rdn[i] && !rds[i]) begin rany = 1'b1; rsel = IW'(i); end
      if (v[i] && wrn[i] && !wrs[i] && (!rdn[i] || fil[i])) begin wany = 1'b1; wsel = IW'(i); end
    end
    if (lock_q)    begin mv = 1'b1; sel = sel_q; sw = sw_q; end
    else if (rany) begin mv = 1'b1; sel = rsel;  sw = 1'b0; end
    else if (wany) begin mv = 1'b1; sel = wsel;  sw = 1'b1; end
    else           begin mv = 1'b0; sel = '0;    sw = 1'b0; end
  end

  always_comb begin
    fidx = '0; pidx = '0;
    for (int i = NE-1; i >= 0; i--) begin
      hit[i]  = v[i] && (la[i] == rl);
      part[i] = v[i] && (la[i][PHI-OFF:PLO-OFF] == rl[PHI-OFF:PLO-OFF]);
      rdc[i]  = v[i] && rdn[i] && !rds[i];
      wrc[i]  = v[i] && wrn[i] && !wrs[i];
      done[i] = (!rdn[i] || fil[i]) && (!wrn[i] || wrs[i]);
      clo[i]  = fil[i] || wrs[i] || (fill_valid && fill_ent == IW'(i)) ||
                (mv && sw && sel == IW'(i) && (!req_store || mem_req_ready));
      if (!v[i]) fidx = IW'(i);
      if (part[i]) pidx = IW'(i);
    end
  end

  always_comb
    for (int b = 0; b < LB; b++)
      fm[b*8 +: 8] = bv[fill_ent][b] ? dat[fill_ent][b*8 +: 8] : fill_data[b*8 +: 8];

  assign req_ready      = !(|(hit & clo)) && ((|hit) || !(&v));
  assign accept         = req_valid && req_ready;
  assign acc            = mv && mem_req_ready;
  assign spec_fwd_valid = accept && !req_store && (|part);
  assign spec_fwd_ent   = pidx;
  assign spec_fwd_data  = dat[pidx];
  assign full_eq        = v[se_q] && (la[se_q] == sl_q);
  assign fwd_confirm    = sv_q && full_eq;
  assign fwd_squash     = sv_q && !full_eq;

  assign mem_req_valid   = mv;
  assign mem_req_write   = sw;
  assign mem_req_id      = sel;
  assign mem_req_addr    = {la[sel], {OFF{1'b0}}};
  assign mem_req_be      = bv[sel];
  assign mem_req_wdata   = dat[sel];
  assign mem_req_nocache = nc[sel];

  assign rsp_valid = fill_valid;
  assign rsp_tags  = wt[fill_ent];
  assign rsp_data  = fm;
  assign rsp_alloc = !nc[fill_ent];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v <= '0; rdn <= '0; rds <= '0; fil <= '0; wrn <= '0; wrs <= '0; nc <= '0;
      lock_q <= 1'b0; sel_q <= '0; sw_q <= 1'b0;
      sv_q <= 1'b0; se_q <= '0; sl_q <= '0;
      for (int i = 0; i < NE; i++) begin
        la[i] <= '0; dat[i] <= '0; bv[i] <= '0; wt[i] <= '0;
      end
    end else begin
      lock_q <= mv && !mem_req_ready;
      sel_q  <= sel;
      sw_q   <= sw;
      sv_q   <= spec_fwd_valid;
      se_q   <= pidx;
      sl_q   <= rl;
      for (int i = 0; i < NE; i++) begin
        if (v[i] && done[i]) v[i] <= 1'b0;
        if (accept && !(|hit) && fidx == IW'(i)) begin
          v[i] <= 1'b1; la[i] <= rl; nc[i] <= req_nocache;
          rdn[i] <= !req_store; wrn[i] <= req_store;
          rds[i] <= 1'b0; fil[i] <= 1'b0; wrs[i] <= 1'b0;
          wt[i] <= req_store ? '0 : (NT'(1) << req_tag);
          bv[i] <= req_store ? req_be : '0;
          for (int b = 0; b < LB; b++)
            dat[i][b*8 +: 8] <= (req_store && req_be[b]) ? req_wdata[b*8 +: 8] : 8'h00;
        end
        if (accept && hit[i]) begin
          nc[i] <= nc[i] | req_nocache;
          if (req_store) begin
            wrn[i] <= 1'b1;
            bv[i]  <= bv[i] | req_be;
            for (int b = 0; b < LB; b++)
              if (req_be[b]) dat[i][b*8 +: 8] <= req_wdata[b*8 +: 8];
          end else begin
            rdn[i] <= 1'b1;
            wt[i]  <= wt[i] | (NT'(1) << req_tag);
          end
        end
        if (acc && sel == IW'(i)) begin
          if (sw) wrs[i] <= 1'b1;
          else    rds[i] <= 1'b1;
        end
        if (fill_valid && fill_ent == IW'(i)) begin
          fil[i] <= 1'b1;
          dat[i] <= fm;
        end
      end
    end
  end
endmodule

module cfb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_store,
  input logic        spec_fwd_valid,
  input logic        fwd_confirm,
  input logic        fwd_squash,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [1:0]  mem_req_id,
  input logic [31:0] mem_req_addr
);
  // R7
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spec_fwd_valid |=> (fwd_confirm != fwd_squash));
  // R7
  no_stray_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_fwd_valid |=> !(fwd_confirm || fwd_squash));
  // R6
  fwd_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spec_fwd_valid |-> (req_valid && req_ready && !req_store));
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) &&
                                           $stable(mem_req_write) && $stable(mem_req_id)));
  // R1
  no_reread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && !mem_req_write) |=>
      !(mem_req_valid && !mem_req_write && mem_req_id == $past(mem_req_id)));
endmodule

bind coalescing_fill_buf cfb_chk u_chk (.*);

// File: tb/coalescing_fill_buf_tb.sv
`timescale 1ns/1ps
module coalescing_fill_buf_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, req_nocache = 0;
  logic [31:0] req_addr = '0;
  logic [2:0] req_tag = '0;
  logic [511:0] req_wdata = '0;
  logic [63:0] req_be = '0;
  logic req_ready, spec_fwd_valid, fwd_confirm, fwd_squash;
  logic [1:0] spec_fwd_ent;
  logic [511:0] spec_fwd_data;
  logic mem_req_valid, mem_req_write, mem_req_nocache;
  logic mem_req_ready = 1'b1;
  logic [1:0] mem_req_id;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_req_be;
  logic [511:0] mem_req_wdata;
  logic fill_valid = 0;
  logic [1:0] fill_ent = '0;
  logic [511:0] fill_data = '0;
  logic rsp_valid, rsp_alloc;
  logic [7:0] rsp_tags;
  logic [511:0] rsp_data;

  int total = 0, bad = 0;
  logic [611:0] exp_mem[$];
  string        exp_mem_r[$];
  logic [520:0] exp_rsp[$];
  string        exp_rsp_r[$];

  coalescing_fill_buf u_dut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [511:0] pat(input logic [31:0] s);
    for (int k = 0; k < 16; k++) pat[k*32 +: 32] = s * 32'h0100_0193 + 32'(k);
  endfunction

  function automatic logic [511:0] mrg(input logic [511:0] o, input logic [511:0] n, input logic [63:0] be);
    mrg = o;
    for (int b = 0; b < 64; b++) if (be[b]) mrg[b*8 +: 8] = n[b*8 +: 8];
  endfunction

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    total++;
    if (a !== e) begin bad++; $display("FAIL %s actual=%h expected=%h", r, a, e); end
  endtask

  task automatic push_mem(input string r, input logic w, input logic nc, input logic [1:0] id,
                          input logic [31:0] ad, input logic [63:0] be, input logic [511:0] d);
    exp_mem.push_back({w, nc, id, ad, be, d});
    exp_mem_r.push_back(r);
  endtask

  task automatic push_rsp(input string r, input logic al, input logic [7:0] t, input logic [511:0] d);
    exp_rsp.push_back({al, t, d});
    exp_rsp_r.push_back(r);
  endtask

  always begin
    @(negedge clk); #2;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      logic [611:0] act;
      act = {mem_req_write, mem_req_nocache, mem_req_id, mem_req_addr,
             mem_req_write ? mem_req_be : 64'h0, mem_req_write ? mem_req_wdata : 512'h0};
      total++;
      if (exp_mem.size() == 0) begin
        bad++; $display("FAIL R1 unexpected request actual=%h expected=none", act[611:576]);
      end else begin
        logic [611:0] e;
        string r;
        e = exp_mem.pop_front(); r = exp_mem_r.pop_front();
        if (act !== e) begin bad++; $display("FAIL %s request actual=%h expected=%h", r, act, e); end
      end
    end
    if (rst_n && rsp_valid) begin
      logic [520:0] act;
      act = {rsp_alloc, rsp_tags, rsp_data};
      total++;
      if (exp_rsp.size() == 0) begin
        bad++; $display("FAIL R2 unexpected broadcast actual=%h expected=none", act[520:512]);
      end else begin
        logic [520:0] e;
        string r;
        e = exp_rsp.pop_front(); r = exp_rsp_r.pop_front();
        if (act !== e) begin bad++; $display("FAIL %s broadcast actual=%h expected=%h", r, act, e); end
      end
    end
  end

  task automatic send(input logic st, input logic nc, input logic [31:0] ad, input logic [2:0] tg,
                      input logic [511:0] d, input logic [63:0] be,
                      output logic sv, output logic [1:0] se, output logic [511:0] sd,
                      output logic cf, output logic sq);
    @(negedge clk);
    req_valid = 1; req_store = st; req_nocache = nc; req_addr = ad; req_tag = tg;
    req_wdata = d; req_be = be;
    #2;
    while (!req_ready) begin @(negedge clk); #2; end
    sv = spec_fwd_valid; se = spec_fwd_ent; sd = spec_fwd_data;
    @(negedge clk);
    req_valid = 0;
    #2;
    cf = fwd_confirm; sq = fwd_squash;
  endtask

  task automatic fill(input logic [1:0] e, input logic [511:0] d);
    @(negedge clk); fill_valid = 1; fill_ent = e; fill_data = d;
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic sv, cf, sq;
    logic [1:0] se;
    logic [511:0] sd;
    logic [511:0] d4, d5;
    localparam logic [31:0] A = 32'h0000_1040, B = 32'h0000_2040, C = 32'h0000_1080, D = 32'h3000_00C0;

    idle(2); rst_n = 1; @(negedge clk); #2;
    chk("R11 ready", req_ready, 1); chk("R11 mem_req_valid", mem_req_valid, 0);
    chk("R11 rsp_valid", rsp_valid, 0); chk("R11 spec", spec_fwd_valid, 0);
    chk("R11 verdict", fwd_confirm | fwd_squash, 0);

    // Same-line loads: one read, one broadcast to all tags
    push_mem("R1 single read", 0, 0, 0, 32'h0000_1040, 0, 0);
    send(0, 0, A, 0, 0, 0, sv, se, sd, cf, sq);
    chk("R6 no entry no forward", sv, 0); chk("R7 no verdict", cf | sq, 0);
    send(0, 0, A + 32'h8, 3, 0, 0, sv, se, sd, cf, sq);
    chk("R6 forward on match", sv, 1); chk("R6 entry", se, 0); chk("R7 confirm", {cf, sq}, 2'b10);
    send(0, 0, A, 5, 0, 0, sv, se, sd, cf, sq);
    chk("R7 confirm again", {cf, sq}, 2'b10);
    idle(3);
    push_rsp("R2 broadcast all waiters", 1, 8'b0010_1001, pat(1));
    fill(0, pat(1));
    idle(4);

    // Partial match only: squash
    push_mem("R1 read A", 0, 0, 0, A, 0, 0);
    send(0, 0, A, 1, 0, 0, sv, se, sd, cf, sq);
    push_mem("R1 read B lowest free", 0, 0, 1, B, 0, 0);
    send(0, 0, B, 2, 0, 0, sv, se, sd, cf, sq);
    chk("R6 partial forward", sv, 1); chk("R6 partial entry", se, 0); chk("R7 squash", {cf, sq}, 2'b01);
    idle(3);
    push_rsp("R2 broadcast B", 1, 8'h04, pat(2));
    fill(1, pat(2));
    push_rsp("R2 broadcast A", 1, 8'h02, pat(3));
    fill(0, pat(3));
    idle(4);

    // Stores merging into pending fill
    push_mem("R1 read for store merge", 0, 0, 0, A, 0, 0);
    send(0, 0, A, 4, 0, 0, sv, se, sd, cf, sq);
    send(1, 0, A, 0, pat(10), 64'hFF, sv, se, sd, cf, sq);
    chk("R6 store never forwards", sv, 0);
    send(1, 0, A, 0, pat(11), 64'h0F, sv, se, sd, cf, sq);
    d4 = mrg(mrg(512'h0, pat(10), 64'hFF), pat(11), 64'h0F);
    send(0, 0, A, 5, 0, 0, sv, se, sd, cf, sq);
    chk("R6 forward data low", sd[63:0], d4[63:0]); chk("R6 forward data high", sd[511:448], 0);
    idle(2);
    push_rsp("R4 fill keeps store bytes", 1, 8'h30, mrg(pat(12), d4, 64'hFF));
    push_mem("R3 single merged write", 1, 0, 0, A, 64'hFF, mrg(pat(12), d4, 64'hFF));
    fill(0, pat(12));
    idle(4);

    // Store-only coalescing while port stalls
    mem_req_ready = 0;
    send(1, 0, C, 0, pat(20), 64'h3, sv, se, sd, cf, sq);
    send(1, 0, C, 0, pat(21), 64'h6, sv, se, sd, cf, sq);
    d5 = mrg(mrg(512'h0, pat(20), 64'h3), pat(21), 64'h6);
    chk("R3 write waiting", {mem_req_valid, mem_req_write}, 2'b11);
    @(negedge clk); #2;
    chk("R10 held addr", mem_req_addr, C & ~32'h3F); chk("R10 held valid", mem_req_valid, 1);
    push_mem("R3 coalesced store write", 1, 0, 0, C & ~32'h3F, 64'h7, d5);
    @(negedge clk); mem_req_ready = 1;
    idle(4);

    // Non-cacheable
    push_mem("R5 nocache read", 0, 1, 0, D, 0, 0);
    send(0, 1, D, 6, 0, 0, sv, se, sd, cf, sq);
    idle(3);
    push_rsp("R5 no allocate", 0, 8'h40, pat(30));
    fill(0, pat(30));
    idle(4);

    // Full buffer stall and free timing
    for (int k = 0; k < 4; k++) begin
      push_mem("R1 fill all", 0, 0, 2'(k), 32'h0001_0000 + 32'(k) * 32'h100, 0, 0);
      send(0, 0, 32'h0001_0000 + 32'(k) * 32'h100, 3'(k), 0, 0, sv, se, sd, cf, sq);
    end
    send(0, 0, 32'h0001_0100, 7, 0, 0, sv, se, sd, cf, sq);
    chk("R8 hit accepted when full", {sv, se, cf}, {1'b1, 2'd1, 1'b1});
    idle(2);
    @(negedge clk); req_valid = 1; req_store = 0; req_nocache = 0; req_addr = 32'h0001_0400; req_tag = 4;
    #2; chk("R8 full stall", req_ready, 0);
    push_rsp("R2 full entry 2", 1, 8'h04, pat(40));
    @(negedge clk); fill_valid = 1; fill_ent = 2; fill_data = pat(40);
    #2; chk("R8 stall during fill", req_ready, 0);
    @(negedge clk); fill_valid = 0;
    #2; chk("R9 still live after fill", req_ready, 0);
    push_mem("R9 reuse freed entry", 0, 0, 2, 32'h0001_0400, 0, 0);
    @(negedge clk); #2; chk("R9 free next cycle", req_ready, 1);
    @(negedge clk); req_valid = 0;
    idle(3);
    push_rsp("R2 entry 0", 1, 8'h01, pat(41)); fill(0, pat(41));
    push_rsp("R2 entry 1", 1, 8'h82, pat(42)); fill(1, pat(42));
    push_rsp("R2 entry 3", 1, 8'h08, pat(43)); fill(3, pat(43));
    push_rsp("R2 entry 2 reuse", 1, 8'h10, pat(44)); fill(2, pat(44));
    idle(5);

    chk("R1 pending requests", exp_mem.size(), 0);
    chk("R2 pending broadcasts", exp_rsp.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule